// File: doc/BRIEF.md
# Time-Value Transfer Target Decoder

This block sits inside a chip's time-of-day unit. It records which processor core should next receive a copy of the time value. When software asks for the transfer, it checks the request and either sends a single-cycle delivery strobe to that core or drops the request and records why.

Software sets the target by writing a 64-bit control word. The word names the core in one of two ways. In bus-address mode it carries a full 32-bit register address, which must point at the receiving register of one core. In core-ID mode it carries a small core number instead. A later move write is honoured only if all of the following hold: the time-of-day sequencer reports running, the request bit is set, a target is held, and the chosen core says it is ready. Each failure reason sets a sticky flag, which software reads and clears through a small register window.

Three named states drive the block:
- EMPTY: no valid target is held.
- ARMED: a target is held.
- FIRE: a target is held and a delivery strobe goes out in this cycle.

The transitions are:
- EMPTY→ARMED: a valid target write.
- ARMED/FIRE→EMPTY: an invalid target write.
- ARMED/FIRE→FIRE: a qualified move.
- FIRE→ARMED: any other cycle.

Top module: `ttx_target_gate`

## Requirements
- R1: After reset the state is EMPTY, `tb_sent` is all zero and the error flags read as zero.
- R2: A target write (`reg_addr`=0) with `reg_wdata[28]`=1 uses bus-address mode: address = `reg_wdata[63:32]`. The target is valid only if address bits [11:0] equal REG_OFF (0x4A3) and address bits [31:12] equal bits [31:12] of some CORE_BASE entry. That entry's index becomes the target.
- R3: A bus-address target with the wrong low offset or no base match is invalid. It sets error bit 0 (bad target).
- R4: A target write with `reg_wdata[28]`=0 uses core-ID mode. The core number is `reg_wdata[36:32]`, so bit 37 of the 6-bit field [37:32] is dropped. The target is valid when that number is below NCORES; otherwise it sets error bit 0.
- R5: With ID_MODE_EN=0, every core-ID mode target write is invalid and sets error bit 0.
- R6: A move write (`reg_addr`=1) is qualified when all of these hold: `fsm_running`=1, `reg_wdata[63]`=1, a valid target is held, and that core's `core_ready` bit is 1. A qualified move drives exactly that core's `tb_sent` bit high for exactly the one cycle after the write edge.
- R7: A move write that fails records only the first failing check, in this order: not running → error bit 1, request bit clear → bit 2, no target → bit 3, core not ready → bit 4. No strobe is sent.
- R8: Error flags are sticky. A write to the error register (`reg_addr`=2) clears exactly the flags whose bits [4:0] are 1.
- R9: Reads of the target register and of address 3 return zero. A read of the error register returns the flags in bits [4:0], with zero above.
- R10: An invalid target write discards any previously held target, so the state returns to EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 target, 1 move, 2 errors, 3 unused |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational on `reg_rd` |
| fsm_running | input | 1 | Time-of-day sequencer is running |
| core_ready | input | NCORES | Per-core ready to take the time value |
| tb_sent | output | NCORES | Per-core one-cycle delivery strobe |

## Verification
A wrong held target shows up at the first qualified move. The strobe appears on the wrong core, or it is replaced by a no-target flag one cycle after the move edge. A stuck FIRE state shows as a strobe lasting a second cycle. A lost or spurious error flag shows on the very next error read. The decode paths are swept over every 6-bit core-ID field value and over matching and non-matching base and offset combinations. Each path is followed by a move, so a decoding fault is observed within two cycles.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } xfer_st_t;

    localparam logic [1:0] RA_TARGET = 2'd0;
    localparam logic [1:0] RA_MOVE   = 2'd1;
    localparam logic [1:0] RA_ERRS   = 2'd2;

    localparam int ERR_W     = 5;
    localparam int EB_BADTGT = 0;
    localparam int EB_NOTRUN = 1;
    localparam int EB_NOREQ  = 2;
    localparam int EB_NOTGT  = 3;
    localparam int EB_NOTRDY = 4;
endpackage

// File: rtl/ttx_id_decode.sv
module ttx_id_decode #(
    parameter int NCORES     = 4,
    parameter int IDX_W      = 2,
    parameter bit ID_MODE_EN = 1'b1
) (
    input  logic [63:0]      data,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [4:0] core_num;
    assign core_num = data[36:32];

    generate
        if (ID_MODE_EN) begin : g_id_on
            assign hit = int'(core_num) < NCORES;
            assign idx = IDX_W'(core_num);
        end else begin : g_id_off
            assign hit = 1'b0;
            assign idx = '0;
        end
    endgenerate
endmodule

// File: rtl/ttx_base_match.sv
module ttx_base_match #(
    parameter int          NCORES  = 4,
    parameter int          IDX_W   = 2,
    parameter logic [11:0] REG_OFF = 12'h4A3,
    parameter logic [31:0] CORE_BASE [NCORES] = '{32'h2000_0000, 32'h2100_0000,
                                                  32'h2200_0000, 32'h2300_0000}
) (
    input  logic [63:0]      data,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [31:0]       bus_addr;
    logic [NCORES-1:0] match;

    assign bus_addr = data[63:32];

    generate
        for (genvar g = 0; g < NCORES; g++) begin : g_cmp
            assign match[g] = bus_addr[31:12] == CORE_BASE[g][31:12];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = NCORES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = (bus_addr[11:0] == REG_OFF) && (|match);
endmodule

// File: rtl/ttx_target_gate.sv
module ttx_target_gate
    import ttx_pkg::*;
#(
    parameter int          NCORES     = 4,
    parameter bit          ID_MODE_EN = 1'b1,
    parameter logic [11:0] REG_OFF    = 12'h4A3,
    parameter logic [31:0] CORE_BASE [NCORES] = '{32'h2000_0000, 32'h2100_0000,
                                                  32'h2200_0000, 32'h2300_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              fsm_running,
    input  logic [NCORES-1:0] core_ready,
    output logic [NCORES-1:0] tb_sent
);
    localparam int IDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;

    xfer_st_t          state_q, state_d;
    logic [IDX_W-1:0]  tgt_q;
    logic [ERR_W-1:0]  err_q, err_set, err_clr;

    logic              id_hit, bus_hit, tgt_ok;
    logic [IDX_W-1:0]  id_idx, bus_idx, tgt_new;
    logic              wr_tgt, wr_mv, wr_err, mv_go, have_tgt;

    ttx_id_decode #(.NCORES(NCORES), .IDX_W(IDX_W), .ID_MODE_EN(ID_MODE_EN)) u_id (
        .data(reg_wdata), .hit(id_hit), .idx(id_idx)
    );

    ttx_base_match #(.NCORES(NCORES), .IDX_W(IDX_W), .REG_OFF(REG_OFF),
                     .CORE_BASE(CORE_BASE)) u_bus (
        .data(reg_wdata), .hit(bus_hit), .idx(bus_idx)
    );

    assign wr_tgt   = reg_wr && (reg_addr == RA_TARGET);
    assign wr_mv    = reg_wr && (reg_addr == RA_MOVE);
    assign wr_err   = reg_wr && (reg_addr == RA_ERRS);
    assign tgt_ok   = reg_wdata[28] ? bus_hit : id_hit;
    assign tgt_new  = reg_wdata[28] ? bus_idx : id_idx;
    assign have_tgt = (state_q != ST_EMPTY);

    // move qualification, first failing check wins
    always_comb begin
        err_set = '0;
        mv_go   = 1'b0;
        if (wr_tgt && !tgt_ok) err_set[EB_BADTGT] = 1'b1;
        if (wr_mv) begin
            if (!fsm_running)            err_set[EB_NOTRUN] = 1'b1;
            else if (!reg_wdata[63])     err_set[EB_NOREQ]  = 1'b1;
            else if (!have_tgt)          err_set[EB_NOTGT]  = 1'b1;
            else if (!core_ready[tgt_q]) err_set[EB_NOTRDY] = 1'b1;
            else                         mv_go = 1'b1;
        end
        err_clr = wr_err ? reg_wdata[ERR_W-1:0] : '0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_tgt && tgt_ok) state_d = ST_ARMED;
            end
            ST_ARMED, ST_FIRE: begin
                if (wr_tgt)     state_d = tgt_ok ? ST_ARMED : ST_EMPTY;
                else if (mv_go) state_d = ST_FIRE;
                else            state_d = ST_ARMED;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register and held data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            tgt_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_tgt && tgt_ok) tgt_q <= tgt_new;
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    // outputs
    always_comb begin
        tb_sent   = '0;
        reg_rdata = '0;
        if (state_q == ST_FIRE) tb_sent[tgt_q] = 1'b1;
        if (reg_rd && reg_addr == RA_ERRS) reg_rdata = {{(64-ERR_W){1'b0}}, err_q};
    end
endmodule

// File: rtl/ttx_target_gate_chk.sv
module ttx_target_gate_chk
    import ttx_pkg::*;
#(
    parameter int NCORES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [63:0]       reg_wdata,
    input logic              fsm_running,
    input logic [NCORES-1:0] core_ready,
    input logic [NCORES-1:0] tb_sent,
    input logic [ERR_W-1:0]  err_q
);
    a_r6_sent_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tb_sent));

    a_r6_sent_from_move: assert property (@(posedge clk) disable iff (!rst_n)
        (|tb_sent) |-> $past(reg_wr && reg_addr == RA_MOVE && reg_wdata[63] && fsm_running));

    a_r6_sent_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|tb_sent) |-> ((tb_sent & $past(core_ready)) == tb_sent));

    a_r7_stopped_no_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MOVE && !fsm_running) |=> (tb_sent == '0));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(err_q) & ~err_q) != '0) |-> $past(reg_wr && reg_addr == RA_ERRS));
endmodule

bind ttx_target_gate ttx_target_gate_chk #(.NCORES(NCORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fsm_running(fsm_running), .core_ready(core_ready),
    .tb_sent(tb_sent), .err_q(err_q)
);

// File: tb/test_ttx_target_gate.sv
module test_ttx_target_gate;
    localparam int NC = 4;
    localparam logic [31:0] BASES [NC] = '{32'h2000_0000, 32'h2100_0000,
                                          32'h2200_0000, 32'h2300_0000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic          fsm_running = 1'b0;
    logic [NC-1:0] core_ready = '0;
    logic [63:0]   rdata, rdata_bo;
    logic [NC-1:0] sent, sent_bo;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ttx_target_gate i_ttx_target_gate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
        .fsm_running(fsm_running), .core_ready(core_ready), .tb_sent(sent)
    );

    ttx_target_gate #(.ID_MODE_EN(1'b0)) i_ttx_target_gate_bo (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_bo),
        .fsm_running(fsm_running), .core_ready(core_ready), .tb_sent(sent_bo)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v, output logic [63:0] vb);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = rdata; vb = rdata_bo;
        reg_rd = 1'b0;
    endtask

    function automatic logic [63:0] id_word(input int id);
        return {26'b0, 6'(id), 32'h0};
    endfunction

    function automatic logic [63:0] bus_word(input logic [31:0] base, input logic [11:0] off);
        return {base[31:12], off, 32'h1000_0000};
    endfunction

    localparam logic [63:0] MOVE_GO = 64'h8000_0000_0000_0000;

    initial begin
        logic [63:0] v, vb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1
        check("R1 sent", 64'(sent), 0);
        rd(2'd2, v, vb);
        check("R1 errs", v, 0);
        fsm_running = 1'b1; core_ready = '1;
        wr(2'd1, MOVE_GO);
        check("R1 no strobe", 64'(sent), 0);
        rd(2'd2, v, vb);
        check("R1 no target held", v, 64'h08);
        wr(2'd2, 64'h1F);

        // R4 / R5: full core-ID field sweep
        for (int id = 0; id < 64; id++) begin
            logic ok;
            ok = (id % 32) < NC;
            wr(2'd0, id_word(id));
            wr(2'd1, MOVE_GO);
            check("R4 strobe", 64'(sent), ok ? 64'(1 << (id % 32)) : 64'd0);
            check("R5 bus-only strobe", 64'(sent_bo), 0);
            rd(2'd2, v, vb);
            check("R4 errs", v, ok ? 64'd0 : 64'h09);
            check("R5 bus-only errs", vb, 64'h09);
            wr(2'd2, 64'h1F);
        end

        // R2 / R3: bus-address sweep
        for (int c = 0; c < 6; c++) begin
            for (int o = 0; o < 2; o++) begin
                logic [31:0] b;
                logic [11:0] off;
                logic ok;
                b   = (c < NC) ? BASES[c] : ((c == 4) ? 32'h3000_0000 : 32'h2000_1000);
                off = (o == 0) ? 12'h4A3 : 12'h4A2;
                ok  = (c < NC) && (o == 0);
                wr(2'd0, bus_word(b, off));
                wr(2'd1, MOVE_GO);
                check(ok ? "R2 strobe" : "R3 strobe", 64'(sent), ok ? 64'(1 << c) : 64'd0);
                check("R2 bus-only strobe", 64'(sent_bo), ok ? 64'(1 << c) : 64'd0);
                rd(2'd2, v, vb);
                check(ok ? "R2 errs" : "R3 errs", v, ok ? 64'd0 : 64'h09);
                wr(2'd2, 64'h1F);
            end
        end

        // R6 / R7: qualification on core 2
        wr(2'd0, id_word(2));
        fsm_running = 1'b0;
        wr(2'd1, MOVE_GO);
        check("R7 not running", 64'(sent), 0);
        rd(2'd2, v, vb);
        check("R7 not running flag", v, 64'h02);
        wr(2'd2, 64'h1F);
        fsm_running = 1'b1;
        wr(2'd1, 64'h0);
        check("R7 no request bit", 64'(sent), 0);
        rd(2'd2, v, vb);
        check("R7 no request flag", v, 64'h04);
        wr(2'd2, 64'h1F);
        for (int r = 0; r < 16; r++) begin
            logic rdy;
            core_ready = 4'(r);
            rdy = r[2];
            wr(2'd1, MOVE_GO);
            check("R6 ready gating", 64'(sent), rdy ? 64'h4 : 64'h0);
            @(posedge clk);
            #1 check("R6 single cycle", 64'(sent), 0);
            rd(2'd2, v, vb);
            check("R7 not ready flag", v, rdy ? 64'h0 : 64'h10);
            wr(2'd2, 64'h1F);
        end
        core_ready = '1;

        // R6 back-to-back moves
        wr(2'd1, MOVE_GO);
        check("R6 first of pair", 64'(sent), 64'h4);
        wr(2'd1, MOVE_GO);
        check("R6 second of pair", 64'(sent), 64'h4);

        // R9 reads
        rd(2'd0, v, vb);
        check("R9 target read zero", v, 0);
        rd(2'd3, v, vb);
        check("R9 unused read zero", v, 0);

        // R10 + R7 priority
        wr(2'd0, bus_word(32'h3000_0000, 12'h4A3));
        fsm_running = 1'b0;
        wr(2'd1, 64'h0);
        rd(2'd2, v, vb);
        check("R7 first failure only", v, 64'h03);
        fsm_running = 1'b1;
        wr(2'd1, MOVE_GO);
        check("R10 old target dropped", 64'(sent), 0);

        // R8 sticky and partial clear
        repeat (5) @(posedge clk);
        rd(2'd2, v, vb);
        check("R8 sticky", v, 64'h0B);
        wr(2'd2, 64'h02);
        rd(2'd2, v, vb);
        check("R8 partial clear", v, 64'h09);
        wr(2'd2, 64'h1F);
        rd(2'd2, v, vb);
        check("R8 full clear", v, 64'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule